// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block holds the on/off state of every crosspoint in an 8-column by 12-row analog switch matrix, one storage bit per crosspoint. A controller presents a column index, a row code and a data bit, then raises a strobe. While the strobe is high, the addressed cell tracks the data input. When the strobe falls, the cell keeps the last value it saw. A master clear input empties the whole store at once and takes precedence over any write in progress.

Every control input is sampled in one system clock domain. A multi-stage sampler keeps the clear, strobe, data and address bits aligned with each other. The stored bits drive the switch-enable vector directly, and bit `col*12 + row` controls the crosspoint between column `col` and row `row`. The 4-bit row code has holes in it. Codes 0..5 select rows 0..5 and codes 8..13 select rows 6..11. Codes 6, 7, 14 and 15 select no cell, so a strobe on one of them changes nothing.

Top module: `xpoint_ctrl_mem`

## Requirements
- R1: A high `clr_in` forces every bit of `sw_en` to 0. The clear is visible at the third rising clock edge after `clr_in` is first sampled high.
- R2: With `row_code` from 0 to 5, a strobed write of 1 sets `sw_en[col_sel*12 + row_code]`.
- R3: With `row_code` from 8 to 13, a strobed write of 1 sets `sw_en[col_sel*12 + row_code - 2]`.
- R4: A strobe with `row_code` equal to 6, 7, 14 or 15 leaves all of `sw_en` unchanged.
- R5: A write changes only the addressed bit. A write of 0 clears that bit, and every other bit keeps its value.
- R6: While `stb_in` is high, the addressed bit follows `data_in`, delayed by the same three-edge latency as R1.
- R7: After `stb_in` falls, the addressed bit keeps the last `data_in` value sampled while the strobe was high. While `stb_in` is low, changes on `data_in`, `col_sel` and `row_code` have no effect.
- R8: While `clr_in` is high, a strobe in progress cannot set any bit. If the strobe is still high after the clear ends, writing resumes.
- R9: A low `rst_n` at a clock edge synchronously clears the sampler stages and all stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_in | input | 1 | Master clear, active high |
| stb_in | input | 1 | Write strobe, active high |
| data_in | input | 1 | Value written to the addressed cell |
| col_sel | input | 3 | Column index 0..7 |
| row_code | input | 4 | Row code with holes at 6, 7, 14 and 15 |
| sw_en | output | 96 | Crosspoint enables, bit col*12+row |

## Verification
The stored bits drive the outputs directly, so a corrupted cell shows up on `sw_en` in the same cycle it is written. A decode error can take three forms: a bit that sets at the wrong index, a hole code that sets a real cell, or a write that moves two bits at once. Each appears three clock edges after the strobe is sampled. Sweeping all 128 column and code pairs exposes every one of these. Capture errors are separated out by a strobe falling while data changes and by a clear overlapping a strobe.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
    // Matrix geometry shared by design and checker
    localparam int COLS       = 8;
    localparam int BANK_ROWS  = 6;
    localparam int BANKS      = 2;
    localparam int ROWS       = BANK_ROWS * BANKS;
    localparam int COL_W      = $clog2(COLS);
    localparam int OFF_W      = $clog2(BANK_ROWS);
    localparam int ROW_CODE_W = OFF_W + $clog2(BANKS);
    localparam int CELLS      = COLS * ROWS;

    // Row code that selects physical row r: bank in the upper bits, offset below
    function automatic int code_of_row(input int r);
        return ((r / BANK_ROWS) << OFF_W) | (r % BANK_ROWS);
    endfunction
endpackage

// File: rtl/xpc_sampler.sv
// Multi-stage sampler: carries a bundle of control inputs through STAGES
// flops so that all bits arrive together. It assumes the inputs may be
// asynchronous to clk. Synchronous active-low reset clears every stage.
module xpc_sampler #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the bundle one stage toward the output
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/xpc_decode.sv
// Address decoder: turns column index and row code into a one-hot cell
// select qualified by the strobe. Row codes whose in-bank offset is beyond
// BANK_ROWS, or whose bank is beyond BANKS, select nothing.
module xpc_decode #(
    parameter int COLS       = xpc_pkg::COLS,
    parameter int ROWS       = xpc_pkg::ROWS,
    parameter int COL_W      = xpc_pkg::COL_W,
    parameter int ROW_CODE_W = xpc_pkg::ROW_CODE_W
) (
    input  logic                  stb,
    input  logic [COL_W-1:0]      col,
    input  logic [ROW_CODE_W-1:0] row,
    output logic [COLS*ROWS-1:0]  sel
);
    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            for (genvar r = 0; r < ROWS; r++) begin : g_row
                localparam logic [COL_W-1:0]      C_IDX  = COL_W'(c);
                localparam logic [ROW_CODE_W-1:0] R_CODE = ROW_CODE_W'(xpc_pkg::code_of_row(r));
                // Purpose: match this crosspoint's address under the strobe
                assign sel[c*ROWS + r] = stb && (col == C_IDX) && (row == R_CODE);
            end
        end
    endgenerate
endmodule

// File: rtl/xpc_cells.sv
// Cell store: one bit per crosspoint. A selected cell loads the shared data
// bit every cycle its select is high, which is the clocked form of a
// transparent latch. Clear beats any select. It assumes a one-hot-or-zero select.
module xpc_cells #(
    parameter int CELLS = xpc_pkg::CELLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dat,
    input  logic [CELLS-1:0] sel,
    output logic [CELLS-1:0] q
);
    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            // Purpose: hold, clear or load one crosspoint bit
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (clr)    q[i] <= 1'b0;
                else if (sel[i]) q[i] <= dat;
            end
        end
    endgenerate
endmodule

// File: rtl/xpoint_ctrl_mem.sv
// Crosspoint control memory top. It samples clear, strobe, data and address
// together, decodes the address, and updates the cell store. It assumes
// address and data are held around the strobe edges for longer than the
// sampler latency. The output is the cell store itself.
module xpoint_ctrl_mem #(
    parameter int COLS        = xpc_pkg::COLS,
    parameter int ROWS        = xpc_pkg::ROWS,
    parameter int COL_W       = xpc_pkg::COL_W,
    parameter int ROW_CODE_W  = xpc_pkg::ROW_CODE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_in,
    input  logic                  stb_in,
    input  logic                  data_in,
    input  logic [COL_W-1:0]      col_sel,
    input  logic [ROW_CODE_W-1:0] row_code,
    output logic [COLS*ROWS-1:0]  sw_en
);
    localparam int CELLS = COLS * ROWS;
    localparam int BUS_W = 3 + COL_W + ROW_CODE_W;

    logic                  clr_q, stb_q, dat_q;
    logic [COL_W-1:0]      col_q;
    logic [ROW_CODE_W-1:0] row_q;
    logic [CELLS-1:0]      wr_sel;

    xpc_sampler #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_in, stb_in, data_in, col_sel, row_code}),
        .q     ({clr_q, stb_q, dat_q, col_q, row_q})
    );

    xpc_decode #(.COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_CODE_W(ROW_CODE_W)) u_dec (
        .stb (stb_q),
        .col (col_q),
        .row (row_q),
        .sel (wr_sel)
    );

    xpc_cells #(.CELLS(CELLS)) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_q),
        .dat   (dat_q),
        .sel   (wr_sel),
        .q     (sw_en)
    );
endmodule

// File: rtl/xpc_checker.sv
// Property checker for the crosspoint control memory, bound into the top.
module xpc_checker #(
    parameter int COLS       = xpc_pkg::COLS,
    parameter int ROWS       = xpc_pkg::ROWS,
    parameter int COL_W      = xpc_pkg::COL_W,
    parameter int ROW_CODE_W = xpc_pkg::ROW_CODE_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr_q,
    input logic                  stb_q,
    input logic                  dat_q,
    input logic [COL_W-1:0]      col_q,
    input logic [ROW_CODE_W-1:0] row_q,
    input logic [COLS*ROWS-1:0]  wr_sel,
    input logic [COLS*ROWS-1:0]  sw_en
);
    localparam int OFF_W = xpc_pkg::OFF_W;
    localparam int BANK_ROWS = xpc_pkg::BANK_ROWS;

    logic hole;
    int   idx;
    always_comb begin
        hole = (int'(row_q[OFF_W-1:0]) >= BANK_ROWS) ||
               (int'(row_q >> OFF_W) >= ROWS / BANK_ROWS);
        idx  = int'(col_q) * ROWS + int'(row_q >> OFF_W) * BANK_ROWS + int'(row_q[OFF_W-1:0]);
        if (hole) idx = 0;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_q) |-> (sw_en == '0)); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R5
    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !clr_q) |-> ($countones(sw_en ^ $past(sw_en)) <= 1)); // R5
    AST_HOLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && stb_q && hole && !clr_q) |-> $stable(sw_en)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !stb_q && !clr_q) |-> $stable(sw_en)); // R7
    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && stb_q && !hole && !clr_q) |-> (sw_en[$past(idx)] == $past(dat_q))); // R6
endmodule

bind xpoint_ctrl_mem xpc_checker #(
    .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_CODE_W(ROW_CODE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_q  (clr_q),
    .stb_q  (stb_q),
    .dat_q  (dat_q),
    .col_q  (col_q),
    .row_q  (row_q),
    .wr_sel (wr_sel),
    .sw_en  (sw_en)
);

// File: tb/xpoint_ctrl_mem_bench.sv
module xpoint_ctrl_mem_bench;
    localparam int NC = 8;
    localparam int NR = 12;
    localparam int NCELL = NC * NR;

    typedef struct {
        logic [NCELL-1:0] exp;
        string            tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_in = 1'b0;
    logic             stb_in = 1'b0;
    logic             data_in = 1'b0;
    logic [2:0]       col_sel = '0;
    logic [3:0]       row_code = '0;
    logic [NCELL-1:0] sw_en;

    logic [NCELL-1:0] model = '0;
    item_t            sb_q[$];
    int               n_chk = 0;
    int               n_bad = 0;
    bit               done = 1'b0;

    always #2 clk = ~clk;

    xpoint_ctrl_mem u_xpoint_ctrl_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_in   (clr_in),
        .stb_in   (stb_in),
        .data_in  (data_in),
        .col_sel  (col_sel),
        .row_code (row_code),
        .sw_en    (sw_en)
    );

    function automatic int row_of(input int code);
        if (code < 6) return code;
        if (code >= 8 && code < 14) return code - 2;
        return -1;
    endfunction

    // Monitor: pops each expected item and compares it away from the rising edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (sw_en !== it.exp) begin
                n_bad++;
                $display("FAIL %s: sw_en=%h expected=%h", it.tag, sw_en, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Push the current model after the three-edge latency has elapsed
    task automatic expect_now(input string tag);
        item_t it;
        tick(4);
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
        tick(2);
    endtask

    task automatic write_cell(input int col, input int code, input logic d, input string tag);
        col_sel = 3'(col); row_code = 4'(code); data_in = d; stb_in = 1'b1;
        tick(3);
        stb_in = 1'b0;
        if (row_of(code) >= 0) model[col*NR + row_of(code)] = d;
        expect_now(tag);
    endtask

    task automatic clear_all(input string tag);
        clr_in = 1'b1;
        tick(3);
        clr_in = 1'b0;
        model = '0;
        expect_now(tag);
    endtask

    initial begin
        tick(5);
        expect_now("R9 reset state");
        rst_n = 1'b1;
        tick(2);
        clear_all("R1 clear after reset");

        // Full address sweep writing ones
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 16; k++) begin
                if (k < 6)       write_cell(c, k, 1'b1, "R2 low bank write");
                else if (k >= 8 && k < 14) write_cell(c, k, 1'b1, "R3 high bank write");
                else             write_cell(c, k, 1'b1, "R4 hole code no effect");
            end
        end

        // Selective zero writes
        write_cell(3, 9, 1'b0, "R5 write zero one cell");
        write_cell(0, 0, 1'b0, "R5 write zero corner");
        write_cell(7, 13, 1'b0, "R5 write zero last cell");
        clear_all("R1 clear full store");

        // Hole codes against a sparse pattern
        write_cell(2, 4, 1'b1, "R2 sparse set");
        write_cell(2, 6, 1'b1, "R4 hole 6");
        write_cell(5, 15, 1'b1, "R4 hole 15");

        // Idle inputs while the strobe is low
        data_in = 1'b1; col_sel = 3'd6; row_code = 4'd10;
        tick(3);
        col_sel = 3'd1; row_code = 4'd1;
        expect_now("R7 idle inputs ignored");

        // Transparent tracking and capture at the falling strobe
        col_sel = 3'd4; row_code = 4'd11; data_in = 1'b1; stb_in = 1'b1;
        model[4*NR + 9] = 1'b1;
        expect_now("R6 follows data high");
        data_in = 1'b0;
        model[4*NR + 9] = 1'b0;
        expect_now("R6 follows data low");
        data_in = 1'b1;
        tick(2);
        stb_in = 1'b0; data_in = 1'b0;
        model[4*NR + 9] = 1'b1;
        expect_now("R7 last value before fall held");

        // Clear overlapping an active strobe
        col_sel = 3'd1; row_code = 4'd8; data_in = 1'b1; stb_in = 1'b1; clr_in = 1'b1;
        model = '0;
        expect_now("R8 clear overrides strobe");
        clr_in = 1'b0;
        model[1*NR + 6] = 1'b1;
        expect_now("R8 write resumes after clear");
        stb_in = 1'b0;
        expect_now("R8 value kept after strobe");

        // Synchronous reset mid-operation
        rst_n = 1'b0;
        model = '0;
        tick(1);
        expect_now("R9 reset clears store");
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule